// File: doc/BRIEF.md
# PHY Delay Register Access Bridge

This block lets a host processor program a small bank of 8-bit PHY delay settings through a single 32-bit control word. The host places an address, a data byte and one of two strobes (write or read) in the word. The bridge then runs a request/acknowledge exchange with the PHY register bank and raises an acknowledge flag in the same word when the access has completed. A read also returns the addressed byte in the word. The acknowledge stays up until the host clears the strobe, so consecutive accesses cannot be mistaken for one another.

A replay sequencer holds a fixed list of address/data pairs, set by parameter. It writes the list into the PHY bank in list order, once after reset and again whenever a resume request arrives. While it runs, host requests wait until it has finished. If a write in the list is not acknowledged within a cycle budget, the sequencer stops at that entry and raises an error flag.

Top module: `phy_access_bridge`

## Requirements
- R1: The control word reads back as: bit 26 acknowledge, bit 25 read strobe, bit 24 write strobe, bits 23:16 last read data, bits 15:8 write data, bits 5:0 address. Bits 31:27 and 7:6 read as zero. Host writes change only the strobes, the write data and the address.
- R2: A write with only the write strobe set stores the data byte at a mapped address, and the acknowledge is set no later than the 4th clock edge after the edge that loaded the strobe. The mapped addresses are 0x00 to 0x08 and 0x0B to 0x0D.
- R3: A read with only the read strobe set places the addressed byte in bits 23:16 no later than the edge on which the acknowledge rises. A read of an unmapped address returns 0x00 and is still acknowledged.
- R4: The acknowledge stays set while the strobe is held. It is clear no more than one clock edge after the edge that clears the strobe.
- R5: While both strobes are set, no acknowledge is given and no register changes.
- R6: A write to an unmapped address is never acknowledged and changes no register. After the host clears the strobe, the next access completes normally.
- R7: After reset, the replay list is written into the bank in list order, and busy is high from reset until the last entry is acknowledged. A host access requested while busy is high is served only after the replay ends.
- R8: A one-cycle resume request starts a new replay pass, which restores the listed values over any that the host wrote.
- R9: If a listed write gets no acknowledge within REPLAY_TIMEOUT cycles, the replay stops at that entry and sets the error flag. Later entries are not written. The error flag clears when the next pass starts.
- R10: Reset clears the control word to zero and the error flag to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Load the control word from host_wdata |
| host_wdata | input | 32 | Control word value written by the host |
| host_rdata | output | 32 | Current control word, with acknowledge and read data |
| resume_req | input | 1 | One-cycle request to replay the parameter list |
| replay_busy | output | 1 | Replay pass in progress |
| replay_err | output | 1 | Last replay pass stopped on an unacknowledged write |

## Verification
A wrong handshake state shows up directly at the control word. An acknowledge that never rises, rises while both strobes are set, or does not fall within one edge after the strobe drops is visible within a few cycles of the access. Wrong bank contents or a skipped replay entry show only when the address is read back later, so the bench reads every written or replayed address through the host port. A sequencer that does not stop at a failing entry is caught by reading an address that comes after the failing entry and finding data there.

// File: rtl/phy_bridge_pkg.sv
package phy_bridge_pkg;
  localparam int ADDR_W    = 6;
  localparam int DATA_W    = 8;
  localparam int ENTRY_W   = 16;  // {addr byte, data byte}
  localparam int ACK_BIT   = 26;
  localparam int RD_BIT    = 25;
  localparam int WR_BIT    = 24;
  localparam int RDATA_LSB = 16;
  localparam int WDATA_LSB = 8;

  // delay settings live at 0x00..0x08 and 0x0B..0x0D
  function automatic logic is_mapped(input logic [ADDR_W-1:0] a);
    return (a <= 6'h08) || (a >= 6'h0B && a <= 6'h0D);
  endfunction
endpackage

// File: rtl/phy_delay_bank.sv
module phy_delay_bank
  import phy_bridge_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_wr,
  input  logic          req_rd,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          done,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DEPTH*DW-1:0] flat;

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    if (is_mapped(AW'(g))) begin : g_reg
      logic [DW-1:0] q;
      always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else if (req_wr && req_addr == AW'(g)) q <= req_wdata;
      end
      assign flat[g*DW +: DW] = q;
    end else begin : g_hole
      assign flat[g*DW +: DW] = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      done  <= 1'b0;
      rdata <= '0;
    end else begin
      done <= req_rd | (req_wr & is_mapped(req_addr));
      if (req_rd) rdata <= flat[req_addr*DW +: DW];
    end
  end

  // R6: an unmapped write never completes
  p_unmapped_silent_r6: assert property (@(posedge clk) disable iff (rst)
    (req_wr && !req_rd && !is_mapped(req_addr)) |=> !done);
endmodule

// File: rtl/phy_host_port.sv
module phy_host_port
  import phy_bridge_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          host_wr,
  input  logic [31:0]   host_wdata,
  output logic [31:0]   host_rdata,
  input  logic          hold_off,
  input  logic          bank_done,
  input  logic [DW-1:0] bank_rdata,
  output logic          req_wr,
  output logic          req_rd,
  output logic [AW-1:0] req_addr,
  output logic [DW-1:0] req_wdata,
  output logic          idle
);
  typedef enum logic [1:0] {H_IDLE, H_WAIT, H_HOLD} hstate_t;
  hstate_t       state;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q, rdata_q;
  logic          wr_q, rd_q, ack_q;
  logic          one_strobe, go;
  logic          unused_word;

  assign unused_word = ^{host_wdata[31:26], host_wdata[23:16], host_wdata[7:6]};
  assign one_strobe  = wr_q ^ rd_q;
  assign go          = (state == H_IDLE) && one_strobe && !hold_off;
  assign req_wr      = go & wr_q;
  assign req_rd      = go & rd_q;
  assign req_addr    = addr_q;
  assign req_wdata   = wdata_q;
  assign idle        = (state == H_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= H_IDLE; addr_q <= '0; wdata_q <= '0; rdata_q <= '0;
      wr_q <= 1'b0; rd_q <= 1'b0; ack_q <= 1'b0;
    end else begin
      if (host_wr) begin
        addr_q  <= host_wdata[AW-1:0];
        wdata_q <= host_wdata[WDATA_LSB +: DW];
        wr_q    <= host_wdata[WR_BIT];
        rd_q    <= host_wdata[RD_BIT];
      end
      case (state)
        H_IDLE: if (go) state <= H_WAIT;
        H_WAIT:
          if (!one_strobe) state <= H_IDLE;
          else if (bank_done) begin
            state <= H_HOLD;
            ack_q <= 1'b1;
            if (rd_q) rdata_q <= bank_rdata;
          end
        H_HOLD:
          if (!one_strobe) begin
            state <= H_IDLE;
            ack_q <= 1'b0;
          end
        default: state <= H_IDLE;
      endcase
    end
  end

  always_comb begin
    host_rdata = '0;
    host_rdata[ACK_BIT] = ack_q;
    host_rdata[RD_BIT]  = rd_q;
    host_rdata[WR_BIT]  = wr_q;
    host_rdata[RDATA_LSB +: DW] = rdata_q;
    host_rdata[WDATA_LSB +: DW] = wdata_q;
    host_rdata[AW-1:0] = addr_q;
  end

  // R4: acknowledge held with the strobe, dropped one edge after it
  p_ack_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (ack_q && one_strobe) |=> ack_q);
  p_ack_drop_r4: assert property (@(posedge clk) disable iff (rst)
    (ack_q && !one_strobe) |=> !ack_q);
  // R5: both strobes never produce an acknowledge
  p_both_no_ack_r5: assert property (@(posedge clk) disable iff (rst)
    (!ack_q && wr_q && rd_q) |=> !ack_q);
endmodule

// File: rtl/phy_replay_seq.sv
module phy_replay_seq
  import phy_bridge_pkg::*;
#(
  parameter int AW      = ADDR_W,
  parameter int DW      = DATA_W,
  parameter int LEN     = 4,
  parameter int TIMEOUT = 2500,
  parameter logic [LEN*ENTRY_W-1:0] LIST = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          resume_req,
  input  logic          host_idle,
  input  logic          bank_done,
  output logic          req_wr,
  output logic [AW-1:0] req_addr,
  output logic [DW-1:0] req_wdata,
  output logic          busy,
  output logic          pend,
  output logic          err
);
  localparam int IDX_W = (LEN > 1) ? $clog2(LEN) : 1;
  localparam int CNT_W = $clog2(TIMEOUT + 1);

  typedef enum logic [1:0] {R_IDLE, R_ISSUE, R_WAIT} rstate_t;
  rstate_t            state;
  logic [IDX_W-1:0]   idx;
  logic [CNT_W-1:0]   cnt;
  logic [ENTRY_W-1:0] entry;
  logic               unused_entry;

  assign entry        = LIST[idx*ENTRY_W +: ENTRY_W];
  assign unused_entry = ^entry[ENTRY_W-1:DW+AW];
  assign req_addr     = entry[DW +: AW];
  assign req_wdata    = entry[DW-1:0];
  assign req_wr       = (state == R_ISSUE);
  assign busy         = (state != R_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= R_ISSUE; idx <= '0; cnt <= '0; err <= 1'b0; pend <= 1'b0;
    end else begin
      pend <= pend | resume_req;
      case (state)
        R_IDLE:
          if (pend && host_idle) begin
            state <= R_ISSUE; idx <= '0; err <= 1'b0; pend <= resume_req;
          end
        R_ISSUE: begin
          state <= R_WAIT;
          cnt   <= '0;
        end
        R_WAIT:
          if (bank_done) begin
            if (idx == IDX_W'(LEN - 1)) state <= R_IDLE;
            else begin
              idx   <= idx + 1'b1;
              state <= R_ISSUE;
            end
          end else if (cnt == CNT_W'(TIMEOUT - 1)) begin
            err   <= 1'b1;
            state <= R_IDLE;
          end else cnt <= cnt + 1'b1;
        default: state <= R_IDLE;
      endcase
    end
  end

  // R7: one request per entry, then a wait for its completion
  p_one_req_r7: assert property (@(posedge clk) disable iff (rst)
    req_wr |=> !req_wr);
  // R9: an error only stands once the pass has stopped
  p_err_stopped_r9: assert property (@(posedge clk) disable iff (rst)
    err |-> !busy);
endmodule

// File: rtl/phy_access_bridge.sv
module phy_access_bridge
  import phy_bridge_pkg::*;
#(
  parameter int REPLAY_LEN     = 4,
  parameter int REPLAY_TIMEOUT = 2500,
  parameter logic [REPLAY_LEN*ENTRY_W-1:0] REPLAY_LIST =
    {16'h0D5A, 16'h0B3C, 16'h0811, 16'h0007}
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        host_wr,
  input  logic [31:0] host_wdata,
  output logic [31:0] host_rdata,
  input  logic        resume_req,
  output logic        replay_busy,
  output logic        replay_err
);
  logic              h_wr, h_rd, h_idle, r_wr, r_pend;
  logic [ADDR_W-1:0] h_addr, r_addr, b_addr;
  logic [DATA_W-1:0] h_wdata, r_wdata, b_wdata, b_rdata;
  logic              b_wr, b_rd, b_done;

  assign b_wr    = replay_busy ? r_wr    : h_wr;
  assign b_rd    = replay_busy ? 1'b0    : h_rd;
  assign b_addr  = replay_busy ? r_addr  : h_addr;
  assign b_wdata = replay_busy ? r_wdata : h_wdata;

  phy_host_port u_host (
    .clk(clk), .rst(rst), .host_wr(host_wr), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .hold_off(replay_busy | r_pend),
    .bank_done(b_done), .bank_rdata(b_rdata), .req_wr(h_wr), .req_rd(h_rd),
    .req_addr(h_addr), .req_wdata(h_wdata), .idle(h_idle));

  phy_replay_seq #(.LEN(REPLAY_LEN), .TIMEOUT(REPLAY_TIMEOUT),
                   .LIST(REPLAY_LIST)) u_replay (
    .clk(clk), .rst(rst), .resume_req(resume_req), .host_idle(h_idle),
    .bank_done(b_done), .req_wr(r_wr), .req_addr(r_addr),
    .req_wdata(r_wdata), .busy(replay_busy), .pend(r_pend),
    .err(replay_err));

  phy_delay_bank u_bank (
    .clk(clk), .rst(rst), .req_wr(b_wr), .req_rd(b_rd), .req_addr(b_addr),
    .req_wdata(b_wdata), .done(b_done), .rdata(b_rdata));

  // R7: the host is not served while a replay pass runs
  p_host_defer_r7: assert property (@(posedge clk) disable iff (rst)
    replay_busy |-> !(h_wr || h_rd));
endmodule

// File: tb/tb_phy_access_bridge.sv
module tb_phy_access_bridge;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [31:0] wword = '0;
  logic resume_a = 1'b0, resume_b = 1'b0;
  logic [31:0] rd_a, rd_b;
  logic busy_a, busy_b, err_a, err_b;
  logic sel = 1'b0;
  int total = 0, bad = 0, cycles = 0;

  always #2 clk = ~clk;  // 250 MHz

  phy_access_bridge dut (
    .clk(clk), .rst(rst), .host_wr(wr_en & !sel), .host_wdata(wword),
    .host_rdata(rd_a), .resume_req(resume_a), .replay_busy(busy_a),
    .replay_err(err_a));

  phy_access_bridge #(.REPLAY_LEN(3), .REPLAY_TIMEOUT(16),
    .REPLAY_LIST({16'h02CC, 16'h0955, 16'h01AA})) dut_bad (
    .clk(clk), .rst(rst), .host_wr(wr_en & sel), .host_wdata(wword),
    .host_rdata(rd_b), .resume_req(resume_b), .replay_busy(busy_b),
    .replay_err(err_b));

  wire [31:0] word = sel ? rd_b : rd_a;
  wire        busy = sel ? busy_b : busy_a;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == 50000) begin
      bad = bad + 1; total = total + 1;
      $display("FAIL watchdog: act=%0d exp<%0d", cycles, 50000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic put(input logic [31:0] v);
    @(negedge clk); wword = v; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  // one full access: fields, strobe, poll acknowledge, hold, release
  task automatic access(input bit is_rd, input logic [5:0] a,
                        input logic [7:0] d, output bit got, output int lat,
                        output logic [7:0] rv, input bit chk_hold);
    logic [31:0] base;
    base = {16'h0, d, 2'b00, a};
    @(negedge clk); wword = base; wr_en = 1'b1;
    @(negedge clk); wword = base | (is_rd ? 32'h0200_0000 : 32'h0100_0000);
    @(negedge clk); wr_en = 1'b0;
    lat = 1;
    while (!word[26] && lat < 40) begin
      @(negedge clk); lat++;
    end
    got = word[26];
    rv  = word[23:16];
    if (got && chk_hold) begin
      repeat (3) @(negedge clk);
      chk(word[26] == 1'b1, "R4 ack held", {31'h0, word[26]}, 32'h1);
    end
    @(negedge clk); wword = base; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
    @(negedge clk);
    if (chk_hold)
      chk(word[26] == 1'b0, "R4 ack drop", {31'h0, word[26]}, 32'h0);
  endtask

  // {is_read, addr, data or expected}
  localparam int NV = 12;
  localparam logic [16:0] VEC [NV] = '{
    {1'b1, 8'h00, 8'h07}, {1'b1, 8'h0D, 8'h5A}, {1'b0, 8'h03, 8'hA5},
    {1'b1, 8'h03, 8'hA5}, {1'b0, 8'h0C, 8'h96}, {1'b1, 8'h0C, 8'h96},
    {1'b1, 8'h08, 8'h11}, {1'b1, 8'h0A, 8'h00}, {1'b1, 8'h3F, 8'h00},
    {1'b0, 8'h05, 8'hFF}, {1'b1, 8'h05, 8'hFF}, {1'b1, 8'h0B, 8'h3C}};

  initial begin
    bit got;
    int lat, n;
    logic [7:0] rv;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(rd_a == 32'h0, "R10 word after reset", rd_a, 32'h0);
    chk(err_a == 1'b0, "R10 err after reset", {31'h0, err_a}, 32'h0);
    chk(busy_a == 1'b1, "R7 busy after reset", {31'h0, busy_a}, 32'h1);
    n = 0;
    while (busy_a && n < 100) begin @(negedge clk); n++; end
    chk(busy_a == 1'b0 && err_a == 1'b0, "R7 replay completes",
        {30'h0, busy_a, err_a}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      access(VEC[i][16], VEC[i][13:8], VEC[i][7:0], got, lat, rv, 1'b1);
      chk(got && lat <= 4, VEC[i][16] ? "R3 read ack" : "R2 write ack",
          lat, 4);
      if (VEC[i][16])
        chk(rv == VEC[i][7:0], "R3 read data", {24'h0, rv}, {24'h0, VEC[i][7:0]});
    end

    // R1: layout of the word, reserved bits zero
    put(32'hFFFF_FFFF);
    chk(word == 32'h033C_FF3F, "R1 word layout", word, 32'h033C_FF3F);
    // R5: both strobes, data 00 to mapped 05
    put(32'h0300_0005);
    repeat (6) @(negedge clk);
    chk(word[26] == 1'b0, "R5 no ack with both strobes", word, 32'h0300_0005);
    put(32'h0000_0005);
    access(1'b1, 6'h05, 8'h00, got, lat, rv, 1'b0);
    chk(got && rv == 8'hFF, "R5 register unchanged", {24'h0, rv}, 32'hFF);

    // R6: unmapped write never acknowledged
    put(32'h0000_770A);
    put(32'h0100_770A);
    repeat (20) @(negedge clk);
    chk(word[26] == 1'b0, "R6 unmapped write no ack", word, 32'h0100_770A);
    put(32'h0000_770A);
    access(1'b1, 6'h0A, 8'h00, got, lat, rv, 1'b0);
    chk(got && rv == 8'h00, "R6 next access after unmapped", {24'h0, rv}, 32'h0);

    // R8/R7: overwrite, resume, host read deferred until replay ends
    access(1'b0, 6'h00, 8'hEE, got, lat, rv, 1'b0);
    access(1'b1, 6'h00, 8'h00, got, lat, rv, 1'b0);
    chk(rv == 8'hEE, "R2 overwrite reg 00", {24'h0, rv}, 32'hEE);
    @(negedge clk); resume_a = 1'b1;
    @(negedge clk); resume_a = 1'b0;
    access(1'b1, 6'h00, 8'h00, got, lat, rv, 1'b0);
    chk(got && lat > 4, "R7 host deferred during replay", lat, 5);
    chk(rv == 8'h07, "R8 resume restores reg 00", {24'h0, rv}, 32'h07);

    // R9: second bridge stops at its unmapped entry
    sel = 1'b1;
    chk(err_b == 1'b1 && busy_b == 1'b0, "R9 error flag set",
        {30'h0, busy_b, err_b}, 32'h1);
    access(1'b1, 6'h01, 8'h00, got, lat, rv, 1'b0);
    chk(rv == 8'hAA, "R9 entry before failure written", {24'h0, rv}, 32'hAA);
    access(1'b1, 6'h02, 8'h00, got, lat, rv, 1'b0);
    chk(rv == 8'h00, "R9 entry after failure skipped", {24'h0, rv}, 32'h0);
    @(negedge clk); resume_b = 1'b1;
    @(negedge clk); resume_b = 1'b0;
    @(negedge clk);
    chk(err_b == 1'b0 && busy_b == 1'b1, "R9 error clears on new pass",
        {30'h0, busy_b, err_b}, 32'h2);
    n = 0;
    while (busy_b && n < 200) begin @(negedge clk); n++; end
    chk(err_b == 1'b1, "R9 error set again", {31'h0, err_b}, 32'h1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule